// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the bus of a small microcontroller and decides when the memory and logic behind it may go into a low-power state. It takes the address-latch strobe and an active-low chip-select input. Both are brought into the domain of a dedicated counting clock, which is separate from the system clock. In that domain, each edge on either signal is treated as bus activity. A short idle timer counts counting-clock cycles in which no activity is seen. When the timer reaches its terminal value and automatic mode is enabled, the power-down flag rises.

A force bit raises the power-down flag at once, whatever the timer holds. The chip-select input also acts as a gate on the memory select qualifiers. While it is high, every qualifier is held inactive. While it is low, each qualifier follows its request. The gate acts only on the selects. The level of the chip-select input does not change the power-down state or any held output.

Top module: `bus_idle_pdn`

## Requirements
- R1: With `auto_en_i`=1 and no activity, `pdn_o` is 0 after 14 counting-clock edges counted from a timer clear, and becomes 1 on the 15th edge.
- R2: A transition of `strobe_i` in either direction clears the idle timer. The clear happens on the third counting-clock edge after the input changes: two synchronizer stages, then the edge detector. Toggling `strobe_i` every cycle keeps `pdn_o` at 0.
- R3: A transition of `csel_ni` in either direction clears the idle timer, with the same three-edge latency as the strobe.
- R4: With `auto_en_i`=0 and `force_i`=0, `pdn_o` stays 0 whatever the idle count. Setting `auto_en_i` to 1 while the timer is full raises `pdn_o` without waiting for a clock edge.
- R5: With `force_i`=1, `pdn_o` is 1 without waiting for a clock edge, regardless of the timer or of `auto_en_i`.
- R6: With `rst_ni`=0, the timer is cleared and `pdn_o` is 0 (with `force_i`=0) without waiting for a clock edge. Release of reset is synchronized to `clk_i`.
- R7: The timer saturates at 15 and does not wrap, so `pdn_o` stays 1 through any number of further idle edges.
- R8: After activity while `pdn_o` is 1 from the timer, `pdn_o` stays 1 for two more edges and returns to 0 on the third edge, unless `force_i` is 1.
- R9: `sel_gnt_o` equals `sel_req_i` bit for bit while `csel_ni`=0. It is all zeros while `csel_ni`=1, whatever the request pattern.
- R10: A steady level of `csel_ni` has no effect on the timer. The timer reaches full after 15 idle edges with `csel_ni` held at 1, and likewise with it held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Dedicated counting clock for the idle timer |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | Address-latch strobe from the microcontroller (asynchronous) |
| csel_ni | input | 1 | Active-low chip-select input (asynchronous) |
| auto_en_i | input | 1 | Enables power-down from the idle timer |
| force_i | input | 1 | Forces power-down immediately |
| sel_req_i | input | NSEL | Memory select requests from the decode logic |
| pdn_o | output | 1 | Power-down flag, 1 = power down |
| sel_gnt_o | output | NSEL | Select qualifiers after the chip-select gate |

## Verification
The timer is driven by four kinds of input pattern, each of which tells apart a different fault:
- Long idle runs, sampled on the 14th and 15th edges after a clear, separate a correct terminal count from an off-by-one and show whether the counter saturates or wraps.
- Single strobe edges in both directions, and single chip-select edges in both directions, show which kinds of edge clear the timer, and at exactly which edge the power-down flag falls.
- A strobe that toggles on every cycle must hold the flag low, which exposes a detector that misses edges.
- Combinations of the enable bit, the force bit and the chip-select level, with several request patterns, check the combinational paths to the flag and to the select gate.

// File: rtl/bip_pkg.sv
package bip_pkg;
  // Default geometry of the controller
  localparam int unsigned DEF_CNT_W       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_NSEL        = 4;

  // Bus signals watched for activity, in synchronizer bit order
  typedef struct packed {
    logic csel_n;
    logic strobe;
  } bus_watch_t;

  localparam int unsigned WATCH_W = $bits(bus_watch_t);

  // Idle level of the watched signals, loaded at reset
  localparam bus_watch_t WATCH_IDLE = '{csel_n: 1'b1, strobe: 1'b0};
endpackage

// File: rtl/bip_rst_sync.sv
module bip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift a one in from the bottom once reset is released
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/bip_sync.sv
module bip_sync #(
  parameter int unsigned       W       = 2,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  // One flop rank per stage; each rank takes the previous one
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = async_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bip_activity.sv
module bip_activity #(
  parameter int unsigned  W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] edge_o,
  output logic         act_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= RST_VAL;
    end else begin
      prev_q <= prev_d;
    end
  end

  // Either direction of change is activity
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign edge_o[b] = level_i[b] ^ prev_q[b];
  end

  assign act_o = |edge_o;
endmodule

// File: rtl/bip_idle_cnt.sv
module bip_idle_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  // Register is loaded only on a clear or while below saturation
  assign cnt_en = clr_i | ~at_max;

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = at_max;
endmodule

// File: rtl/bus_idle_pdn.sv
module bus_idle_pdn
  import bip_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned NSEL        = DEF_NSEL
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic            csel_ni,
  input  logic            auto_en_i,
  input  logic            force_i,
  input  logic [NSEL-1:0] sel_req_i,
  output logic            pdn_o,
  output logic [NSEL-1:0] sel_gnt_o
);
  logic             rst_n_q;
  bus_watch_t       watch_raw;
  bus_watch_t       watch_sync;
  logic [WATCH_W-1:0] watch_sync_v;
  logic [WATCH_W-1:0] watch_edge;
  logic             bus_act;
  logic [CNT_W-1:0] idle_cnt;
  logic             cnt_full;

  bip_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  assign watch_raw = '{csel_n: csel_ni, strobe: strobe_i};

  bip_sync #(
    .W       (WATCH_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (WATCH_IDLE)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .async_i (watch_raw),
    .sync_o  (watch_sync_v)
  );

  assign watch_sync = bus_watch_t'(watch_sync_v);

  bip_activity #(
    .W       (WATCH_W),
    .RST_VAL (WATCH_IDLE)
  ) u_act (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .level_i (watch_sync),
    .edge_o  (watch_edge),
    .act_o   (bus_act)
  );

  bip_idle_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .clr_i  (bus_act),
    .cnt_o  (idle_cnt),
    .full_o (cnt_full)
  );

  // Force bit and enable bit act without waiting for the counting clock
  assign pdn_o = force_i | (auto_en_i & cnt_full);

  // Chip-select gate on every select qualifier
  for (genvar i = 0; i < NSEL; i++) begin : g_gate
    assign sel_gnt_o[i] = sel_req_i[i] & ~csel_ni;
  end
endmodule

// File: rtl/bip_pdn_chk.sv
module bip_pdn_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned NSEL  = 4
) (
  input logic             clk_i,
  input logic             rst_n_q,
  input logic             csel_ni,
  input logic             auto_en_i,
  input logic             force_i,
  input logic             bus_act,
  input logic [CNT_W-1:0] idle_cnt,
  input logic             cnt_full,
  input logic             pdn_o,
  input logic [NSEL-1:0]  sel_gnt_o
);
  AST_IDLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_q) (!bus_act && !cnt_full) |=> (idle_cnt == CNT_W'($past(idle_cnt) + 1'b1))); // R1
  AST_AUTO_PDN: assert property (@(posedge clk_i) disable iff (!rst_n_q) (auto_en_i && cnt_full) |-> pdn_o); // R1
  AST_ACT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n_q) bus_act |=> (idle_cnt == '0)); // R2
  AST_NO_AUTO: assert property (@(posedge clk_i) disable iff (!rst_n_q) (!auto_en_i && !force_i) |-> !pdn_o); // R4
  AST_FORCE_PDN: assert property (@(posedge clk_i) disable iff (!rst_n_q) force_i |-> pdn_o); // R5
  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_n_q) (cnt_full && !bus_act) |=> cnt_full); // R7
  AST_SEL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_n_q) csel_ni |-> (sel_gnt_o == '0)); // R9
endmodule

bind bus_idle_pdn bip_pdn_chk #(
  .CNT_W (CNT_W),
  .NSEL  (NSEL)
) u_chk (
  .clk_i     (clk_i),
  .rst_n_q   (rst_n_q),
  .csel_ni   (csel_ni),
  .auto_en_i (auto_en_i),
  .force_i   (force_i),
  .bus_act   (bus_act),
  .idle_cnt  (idle_cnt),
  .cnt_full  (cnt_full),
  .pdn_o     (pdn_o),
  .sel_gnt_o (sel_gnt_o)
);

// File: tb/bus_idle_pdn_bench.sv
`timescale 1ns/1ps
module bus_idle_pdn_bench;
  localparam int NSEL = 4;
  localparam int NVEC = 15;

  logic            clk;
  logic            rst_n;
  logic            strobe;
  logic            csel_n;
  logic            auto_en;
  logic            frc;
  logic [NSEL-1:0] req;
  logic            pdn;
  logic [NSEL-1:0] gnt;

  int tests;
  int fails;

  bus_idle_pdn #(
    .CNT_W       (4),
    .SYNC_STAGES (2),
    .NSEL        (NSEL)
  ) u_bus_idle_pdn (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .strobe_i  (strobe),
    .csel_ni   (csel_n),
    .auto_en_i (auto_en),
    .force_i   (frc),
    .sel_req_i (req),
    .pdn_o     (pdn),
    .sel_gnt_o (gnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: strobe, csel_n, auto_en, force, req[4], edges[8], exp_pdn, exp_gnt[4]
  localparam logic [20:0] TBL [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 8'd3,  1'b0, 4'h0}, // R2 rising strobe clears
    {1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 8'd14, 1'b0, 4'h0}, // R1 14 idle edges
    {1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 8'd1,  1'b1, 4'h0}, // R1 15th edge, R10 csel held 1
    {1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 8'd10, 1'b1, 4'h0}, // R7 saturation
    {1'b0, 1'b1, 1'b1, 1'b0, 4'hA, 8'd2,  1'b1, 4'h0}, // R8 still high 2 edges
    {1'b0, 1'b1, 1'b1, 1'b0, 4'hA, 8'd1,  1'b0, 4'h0}, // R8 R2 falling strobe clears
    {1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 8'd15, 1'b0, 4'hA}, // R3 csel falling clears
    {1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 8'd3,  1'b1, 4'hA}, // R10 full with csel held 0
    {1'b0, 1'b0, 1'b0, 1'b0, 4'hA, 8'd1,  1'b0, 4'hA}, // R4 disabled
    {1'b0, 1'b0, 1'b0, 1'b0, 4'h6, 8'd20, 1'b0, 4'h6}, // R4 long idle disabled
    {1'b0, 1'b0, 1'b1, 1'b0, 4'h6, 8'd1,  1'b1, 4'h6}, // R4 re-enable while full
    {1'b1, 1'b0, 1'b1, 1'b1, 4'h6, 8'd3,  1'b1, 4'h6}, // R5 force with timer cleared
    {1'b1, 1'b0, 1'b1, 1'b0, 4'h6, 8'd1,  1'b0, 4'h6}, // R5 force released
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h5, 8'd3,  1'b0, 4'h0}, // R3 csel rising clears
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h5, 8'd15, 1'b1, 4'h0}  // R1 full again
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    rst_n = 1'b0;
    strobe = 1'b0;
    csel_n = 1'b1;
    auto_en = 1'b1;
    frc = 1'b0;
    req = 4'hA;
    #1;
    check("R6 reset pdn", {31'd0, pdn}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (25) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      strobe  = TBL[v][20];
      csel_n  = TBL[v][19];
      auto_en = TBL[v][18];
      frc     = TBL[v][17];
      req     = TBL[v][16:13];
      repeat (int'(TBL[v][12:5])) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1-set vector %0d pdn", v), {31'd0, pdn}, {31'd0, TBL[v][4]});
      check($sformatf("R9 vector %0d gnt", v), {28'd0, gnt}, {28'd0, TBL[v][3:0]});
    end

    // R6: asynchronous reset drops a high pdn without a clock edge
    check("R6 pdn high before reset", {31'd0, pdn}, 32'd1);
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R6 reset clears pdn at once", {31'd0, pdn}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    strobe = 1'b0;
    csel_n = 1'b1;
    repeat (25) @(negedge clk);

    // R5: force is combinational
    check("R5 idle full pdn", {31'd0, pdn}, 32'd1);
    auto_en = 1'b0;
    #0.5;
    check("R4 enable drop is immediate", {31'd0, pdn}, 32'd0);
    frc = 1'b1;
    #0.5;
    check("R5 force is immediate", {31'd0, pdn}, 32'd1);
    frc = 1'b0;
    auto_en = 1'b1;
    @(negedge clk);

    // R2: strobe toggling every cycle keeps pdn low
    begin
      int seen_high;
      seen_high = 0;
      for (int c = 0; c < 40; c++) begin
        strobe = ~strobe;
        @(negedge clk);
        if (c >= 3 && pdn) seen_high++;
      end
      check("R2 toggling strobe holds pdn low", seen_high, 0);
    end

    // R9: gate passes several request patterns while selected
    csel_n = 1'b0;
    req = 4'hF;
    #0.5;
    check("R9 pass F", {28'd0, gnt}, 32'hF);
    req = 4'h3;
    #0.5;
    check("R9 pass 3", {28'd0, gnt}, 32'h3);
    req = 4'h0;
    #0.5;
    check("R9 pass 0", {28'd0, gnt}, 32'h0);
    req = 4'hF;
    csel_n = 1'b1;
    #0.5;
    check("R9 block F", {28'd0, gnt}, 32'h0);

    summary();
    $finish;
  end
endmodule